// File: doc/BRIEF.md
# Chained receive descriptor DMA engine

This block moves received frames into memory. Software builds a chain of 32-byte descriptors in memory. Each descriptor names a buffer, the size of that buffer, and the next descriptor in the chain. The engine fetches the current descriptor over a word-addressed memory port. It then packs the incoming byte stream into 32-bit little-endian words inside that buffer. When the frame ends, it writes back the stored byte count and a status word. The status word clears the ownership bit, which returns the descriptor to software. The engine then follows the chain.

Software drives a small register port. It writes the first descriptor address, then arms the queue by writing the pointer-high register with the valid bit set. A control register must have both the run bit and the queue enable bit set before the engine does anything. The engine stops in two cases: it finishes a descriptor marked last, or it fetches a descriptor that software does not hand over. Either way it raises a sticky end-of-queue flag and waits to be re-armed. Any frame that starts while the engine cannot take it is dropped and counted.

Top module: `rx_desc_dma`

## Requirements
- R1: After arming, the engine reads four words of the current descriptor, in this order, at word offsets 0 (buffer address), 2 (next descriptor low), 3 (next descriptor high) and 5 (config/status) from the descriptor base. The descriptor is 32-byte aligned, and `mem_addr` is a word address. No other read ever occurs.
- R2: Frame bytes are stored in order into the buffer, little-endian, byte k going to byte lane k mod 4 of word k/4. A final partial word carries zero in its unused upper lanes.
- R3: At frame end, the engine writes the stored byte count into bits 15:0 of word 4, with bits 31:16 zero. It writes status into word 5: bits 31:16 keep the buffer size, bit 15 (owner) is cleared, and bits 0 (end of frame) and 1 (start of frame) are set.
- R4: When a descriptor is not marked last, the next frame lands in the descriptor named by the next-low word of the previous one.
- R5: After completing a descriptor whose next-high word has bit 31 set, the engine raises `eoq_flag` and stops. Frames that follow are not stored.
- R6: Register 3 clears `eoq_flag` when a 1 is written to bit 0. Writing 0 to that bit leaves the flag unchanged.
- R7: Only a write of register 2 with bit 31 set arms the engine, starting at the address held in register 1. A write of register 2 with bit 31 clear starts nothing.
- R8: Register 0 bit 15 (run) and bit 0 (queue enable) must both be 1 for the engine to fetch or accept frames. With only the run bit set, an armed engine touches no memory.
- R9: If a fetched descriptor has owner bit 15 clear, the engine raises `eoq_flag`. It writes nothing to that descriptor and drops the frames that follow.
- R10: A frame longer than the buffer size is truncated. The count reads back as the buffer size, status bits 11 (length exceeded) and 8 (bad frame) are set, and no byte beyond the buffer is written.
- R11: `rx_crc_err` sampled with the last byte sets status bits 12 and 8. A stored length below MIN_LEN sets status bits 4 (short) and 8.
- R12: `drop_count` increases by one for every frame start that the engine cannot accept, and saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 pointer low, 2 pointer high, 3 extended status |
| reg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | Byte present on rx_data |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_crc_err | input | 1 | CRC failure, sampled with the last byte |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| eoq_flag | output | 1 | Sticky end-of-queue indication |
| drop_count | output | DROP_W | Saturating count of dropped frames |

## Verification
The bench runs frames of several shapes through a three-descriptor chain:
- A frame of 70 bytes, which ends on a partial word, shows both the lane order and the zero fill of the last word.
- A frame of exactly 64 bytes carrying a CRC error separates the CRC bits from the short-frame bits at the MIN_LEN boundary.
- A frame of 100 bytes into an 80-byte buffer exposes truncation and any write past the buffer end.
- A 20-byte frame flags a short frame.

Frames are also sent while the engine is stopped for each of the separate reasons: last descriptor reached, pointer written without its valid bit, run bit set without the enable bit, and a descriptor not owned by the engine. Each time, the drop counter and the untouched descriptor memory show that nothing was stored.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  // Word offsets inside a descriptor (eight 32-bit words)
  localparam logic [2:0] W_BUF_LO = 3'd0;
  localparam logic [2:0] W_NXT_LO = 3'd2;
  localparam logic [2:0] W_NXT_HI = 3'd3;
  localparam logic [2:0] W_LEN    = 3'd4;
  localparam logic [2:0] W_CFG    = 3'd5;

  localparam int OWN_BIT  = 15;
  localparam int LAST_BIT = 31;

  // Status bit positions in the config/status word
  localparam int ST_EOF    = 0;
  localparam int ST_SOF    = 1;
  localparam int ST_SHORT  = 4;
  localparam int ST_BAD    = 8;
  localparam int ST_MAXLEN = 11;
  localparam int ST_CRC    = 12;

  localparam int CNT_W = 16;
  localparam int OFF_W = CNT_W - 2;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_BUF, S_RD_NLO, S_RD_NHI, S_RD_CFG, S_CHECK,
    S_READY, S_RECV, S_FLUSH, S_WR_LEN, S_WR_STAT, S_NEXT
  } walk_state_e;

  typedef struct packed {
    logic crc;
    logic short_f;
    logic trunc;
  } frame_flags_t;

  function automatic logic [31:0] make_status(logic [15:0] size, frame_flags_t f);
    logic [31:0] s;
    s            = '0;
    s[31:16]     = size;
    s[ST_EOF]    = 1'b1;
    s[ST_SOF]    = 1'b1;
    s[ST_SHORT]  = f.short_f;
    s[ST_MAXLEN] = f.trunc;
    s[ST_CRC]    = f.crc;
    s[ST_BAD]    = f.crc | f.short_f | f.trunc;
    return s;
  endfunction

  function automatic logic [31:0] put_byte(logic [31:0] w, logic [1:0] lane, logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[{lane, 3'b000} +: 8] = b;
    return r;
  endfunction

endpackage

// File: rtl/rxdma_regs.sv
module rxdma_regs #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              eoq_set,
  input  logic              start_ack,
  output logic              ctl_ok,
  output logic [ADDR_W-3:0] ptr_word,
  output logic              armed,
  output logic              eoq_flag
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_PLO  = 2'd1;
  localparam logic [1:0] A_PHI  = 2'd2;
  localparam logic [1:0] A_XST  = 2'd3;

  logic run_q, qen_q;
  logic kick, w1c;
  logic unused_wd;

  assign kick      = reg_we && (reg_addr == A_PHI) && reg_wdata[31];
  assign w1c       = reg_we && (reg_addr == A_XST) && reg_wdata[0];
  assign ctl_ok    = run_q && qen_q;
  assign unused_wd = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      qen_q    <= 1'b0;
      ptr_word <= '0;
      armed    <= 1'b0;
      eoq_flag <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_CTRL) begin
        run_q <= reg_wdata[15];
        qen_q <= reg_wdata[0];
      end
      if (reg_we && reg_addr == A_PLO)
        ptr_word <= reg_wdata[ADDR_W-1:2];
      if (kick)           armed <= 1'b1;
      else if (start_ack) armed <= 1'b0;
      if (eoq_set)        eoq_flag <= 1'b1;
      else if (w1c)       eoq_flag <= 1'b0;
    end
  end

  // R5
  eoq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoq_set |=> eoq_flag);
  // R6
  eoq_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c && !eoq_set) |=> !eoq_flag);
  // R7
  arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> armed);

endmodule

// File: rtl/rxdma_packer.sv
module rxdma_packer
  import rxdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             take,
  input  logic [7:0]       byte_in,
  input  logic [CNT_W-1:0] size,
  output logic             wr_fire,
  output logic [31:0]      wr_data,
  output logic [OFF_W-1:0] wr_off,
  output logic [CNT_W-1:0] count,
  output logic             trunc,
  output logic [31:0]      part_word,
  output logic             part_pend
);
  logic [CNT_W-1:0] cnt_q, cnt_base;
  logic [31:0]      word_q, word_base, word_put;
  logic             trunc_q, trunc_base, room, lane_last;

  always_comb begin
    cnt_base   = start ? '0   : cnt_q;
    word_base  = start ? '0   : word_q;
    trunc_base = start ? 1'b0 : trunc_q;
    room       = cnt_base < size;
    lane_last  = cnt_base[1:0] == 2'd3;
    word_put   = put_byte(word_base, cnt_base[1:0], byte_in);
    wr_fire    = take && room && lane_last;
    wr_data    = word_put;
    wr_off     = cnt_base[CNT_W-1:2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      word_q  <= '0;
      trunc_q <= 1'b0;
    end else if (take) begin
      if (room) begin
        cnt_q   <= cnt_base + 1'b1;
        word_q  <= lane_last ? '0 : word_put;
        trunc_q <= trunc_base;
      end else begin
        cnt_q   <= cnt_base;
        word_q  <= word_base;
        trunc_q <= 1'b1;
      end
    end
  end

  assign count     = cnt_q;
  assign trunc     = trunc_q;
  assign part_word = word_q;
  assign part_pend = cnt_q[1:0] != 2'd0;

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cnt_q <= size));
  // R10
  no_fire_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !start && cnt_q >= size) |-> !wr_fire);

endmodule

// File: rtl/rxdma_walker.sv
module rxdma_walker
  import rxdma_pkg::*;
#(
  parameter int AW      = 14,
  parameter int MIN_LEN = 64,
  parameter int DROP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_ok,
  input  logic              armed,
  input  logic [AW-1:0]     ptr_word,
  output logic              start_ack,
  output logic              eoq_set,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_crc_err,
  output logic              pk_start,
  output logic              pk_take,
  output logic [CNT_W-1:0]  pk_size,
  input  logic              pk_wr_fire,
  input  logic [31:0]       pk_wr_data,
  input  logic [OFF_W-1:0]  pk_wr_off,
  input  logic [CNT_W-1:0]  pk_count,
  input  logic              pk_trunc,
  input  logic [31:0]       pk_part_word,
  input  logic              pk_part_pend,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic [DROP_W-1:0] drop_count
);
  localparam logic [CNT_W-1:0]  MIN_L    = CNT_W'(MIN_LEN);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  walk_state_e       st_q, st_d;
  logic [AW-1:0]     cur_q, buf_q, nxt_q;
  logic              last_q, crc_q;
  logic [CNT_W-1:0]  size_q;
  logic              accept_sof, byte_in_frame, frame_end, drop_pulse;
  frame_flags_t      flags;
  logic              unused_rd;

  function automatic logic [AW-1:0] dw(logic [AW-1:0] base, logic [2:0] idx);
    return {base[AW-1:3], idx};
  endfunction

  assign unused_rd = ^mem_rdata;
  assign pk_size   = size_q;

  always_comb begin
    accept_sof    = (st_q == S_READY) && ctl_ok && rx_valid && rx_sof;
    byte_in_frame = (st_q == S_RECV) && rx_valid;
    pk_start      = accept_sof;
    pk_take       = accept_sof || byte_in_frame;
    frame_end     = pk_take && rx_eof;
    drop_pulse    = rx_valid && rx_sof && !accept_sof && (st_q != S_RECV);
    flags.crc     = crc_q;
    flags.short_f = pk_count < MIN_L;
    flags.trunc   = pk_trunc;
  end

  always_comb begin
    st_d      = st_q;
    start_ack = 1'b0;
    eoq_set   = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = dw(cur_q, W_BUF_LO);
    mem_wdata = '0;
    unique case (st_q)
      S_IDLE: if (armed && ctl_ok) begin
        start_ack = 1'b1;
        st_d      = S_RD_BUF;
      end
      S_RD_BUF: begin
        mem_req = 1'b1; mem_addr = dw(cur_q, W_BUF_LO); st_d = S_RD_NLO;
      end
      S_RD_NLO: begin
        mem_req = 1'b1; mem_addr = dw(cur_q, W_NXT_LO); st_d = S_RD_NHI;
      end
      S_RD_NHI: begin
        mem_req = 1'b1; mem_addr = dw(cur_q, W_NXT_HI); st_d = S_RD_CFG;
      end
      S_RD_CFG: begin
        mem_req = 1'b1; mem_addr = dw(cur_q, W_CFG); st_d = S_CHECK;
      end
      S_CHECK: begin
        if (mem_rdata[OWN_BIT]) st_d = S_READY;
        else begin
          eoq_set = 1'b1;
          st_d    = S_IDLE;
        end
      end
      S_READY, S_RECV: begin
        if (pk_wr_fire) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = buf_q + AW'(pk_wr_off);
          mem_wdata = pk_wr_data;
        end
        if (frame_end)       st_d = S_FLUSH;
        else if (accept_sof) st_d = S_RECV;
      end
      S_FLUSH: begin
        if (pk_part_pend) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = buf_q + AW'(pk_count[CNT_W-1:2]);
          mem_wdata = pk_part_word;
        end
        st_d = S_WR_LEN;
      end
      S_WR_LEN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dw(cur_q, W_LEN);
        mem_wdata = {16'h0000, pk_count};
        st_d      = S_WR_STAT;
      end
      S_WR_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dw(cur_q, W_CFG);
        mem_wdata = make_status(size_q, flags);
        st_d      = S_NEXT;
      end
      S_NEXT: begin
        if (last_q) begin
          eoq_set = 1'b1;
          st_d    = S_IDLE;
        end else begin
          st_d = S_RD_BUF;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      cur_q      <= '0;
      buf_q      <= '0;
      nxt_q      <= '0;
      last_q     <= 1'b0;
      size_q     <= '0;
      crc_q      <= 1'b0;
      drop_count <= '0;
    end else begin
      st_q <= st_d;
      if (start_ack)                     cur_q  <= ptr_word;
      if (st_q == S_NEXT && !last_q)     cur_q  <= nxt_q;
      if (st_q == S_RD_NLO)              buf_q  <= mem_rdata[AW+1:2];
      if (st_q == S_RD_NHI)              nxt_q  <= mem_rdata[AW+1:2];
      if (st_q == S_RD_CFG)              last_q <= mem_rdata[LAST_BIT];
      if (st_q == S_CHECK)               size_q <= mem_rdata[31:16];
      if (frame_end)                     crc_q  <= rx_crc_err;
      else if (accept_sof)               crc_q  <= 1'b0;
      if (drop_pulse && drop_count != DROP_MAX)
        drop_count <= drop_count + 1'b1;
    end
  end

  // R1
  fetch_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |->
      (mem_addr[2:0] == W_BUF_LO || mem_addr[2:0] == W_NXT_LO ||
       mem_addr[2:0] == W_NXT_HI || mem_addr[2:0] == W_CFG));
  // R3
  owner_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WR_STAT) |-> (mem_req && mem_we && !mem_wdata[OWN_BIT]));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE) |-> !mem_req);
  // R12
  drop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_pulse && drop_count != DROP_MAX) |=> (drop_count == $past(drop_count) + 1'b1));
  // R9
  no_own_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CHECK && !mem_rdata[OWN_BIT]) |=> (st_q == S_IDLE));

endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
  import rxdma_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MIN_LEN = 64,
  parameter int DROP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_crc_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              eoq_flag,
  output logic [DROP_W-1:0] drop_count
);
  localparam int AW = ADDR_W - 2;

  logic             ctl_ok, armed, start_ack, eoq_set;
  logic [AW-1:0]    ptr_word;
  logic             pk_start, pk_take, pk_wr_fire, pk_trunc, pk_part_pend;
  logic [CNT_W-1:0] pk_size, pk_count;
  logic [31:0]      pk_wr_data, pk_part_word;
  logic [OFF_W-1:0] pk_wr_off;

  rxdma_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .eoq_set(eoq_set), .start_ack(start_ack),
    .ctl_ok(ctl_ok), .ptr_word(ptr_word), .armed(armed), .eoq_flag(eoq_flag)
  );

  rxdma_packer packer_i (
    .clk(clk), .rst_n(rst_n), .start(pk_start), .take(pk_take),
    .byte_in(rx_data), .size(pk_size), .wr_fire(pk_wr_fire),
    .wr_data(pk_wr_data), .wr_off(pk_wr_off), .count(pk_count),
    .trunc(pk_trunc), .part_word(pk_part_word), .part_pend(pk_part_pend)
  );

  rxdma_walker #(.AW(AW), .MIN_LEN(MIN_LEN), .DROP_W(DROP_W)) walker_i (
    .clk(clk), .rst_n(rst_n), .ctl_ok(ctl_ok), .armed(armed),
    .ptr_word(ptr_word), .start_ack(start_ack), .eoq_set(eoq_set),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_crc_err(rx_crc_err), .pk_start(pk_start), .pk_take(pk_take),
    .pk_size(pk_size), .pk_wr_fire(pk_wr_fire), .pk_wr_data(pk_wr_data),
    .pk_wr_off(pk_wr_off), .pk_count(pk_count), .pk_trunc(pk_trunc),
    .pk_part_word(pk_part_word), .pk_part_pend(pk_part_pend),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .drop_count(drop_count)
  );

endmodule

// File: tb/rx_desc_dma_tb_top.sv
`timescale 1ns/1ps
module rx_desc_dma_tb_top;
  localparam int ADDR_W = 16;
  localparam int AW     = ADDR_W - 2;
  localparam logic [31:0] SENT = 32'hDEADBEEF;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_we;
  logic [1:0] reg_addr;
  logic [31:0] reg_wdata;
  logic rx_valid, rx_sof, rx_eof, rx_crc_err;
  logic [7:0] rx_data;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic eoq_flag;
  logic [7:0] drop_count;

  logic [31:0] mem [0:(1<<AW)-1];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [AW-1:0] len_a;
    logic [31:0]   len_v;
    logic [AW-1:0] st_a;
    logic [31:0]   st_v;
  } exp_t;
  exp_t exp_q[$];

  logic [AW-1:0] rd_log [0:7];
  int rd_n = 0;

  always #4 clk = ~clk;

  rx_desc_dma dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_crc_err(rx_crc_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .eoq_flag(eoq_flag), .drop_count(drop_count)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, expv);
    end
  endtask

  // scoreboard monitor: completion writes against expected records
  always @(negedge clk) begin
    if (rst_n && mem_req && !mem_we && rd_n < 8) begin
      rd_log[rd_n] = mem_addr;
      rd_n++;
    end
    if (rst_n && mem_req && mem_we && exp_q.size() > 0) begin
      if (mem_addr == exp_q[0].len_a)
        chk(mem_wdata == exp_q[0].len_v, "R3 count word", mem_wdata, exp_q[0].len_v);
      if (mem_addr == exp_q[0].st_a) begin
        chk(mem_wdata == exp_q[0].st_v, "R3/R10/R11 status word", mem_wdata, exp_q[0].st_v);
        void'(exp_q.pop_front());
      end
    end
  end

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((seed * 37 + i * 5 + 1) & 255);
  endfunction

  task automatic push_exp(input int desc_b, input int cnt, input logic [31:0] st);
    exp_t e;
    e.len_a = AW'((desc_b >> 2) + 4);
    e.len_v = 32'(cnt);
    e.st_a  = AW'((desc_b >> 2) + 5);
    e.st_v  = st;
    exp_q.push_back(e);
  endtask

  task automatic set_desc(input int d, input int bufb, input int nxt, input bit last,
                          input int size, input bit own);
    int w;
    w = d >> 2;
    mem[w+0] = 32'(bufb);
    mem[w+1] = 32'h0;
    mem[w+2] = 32'(nxt);
    mem[w+3] = {last, 31'h0};
    mem[w+4] = 32'h0;
    mem[w+5] = {16'(size), own, 15'h0};
    mem[w+6] = 32'h0;
    mem[w+7] = 32'h0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic send_frame(input int n, input int seed, input bit crc);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      rx_valid   = 1'b1;
      rx_data    = pat(seed, i);
      rx_sof     = (i == 0);
      rx_eof     = (i == n - 1);
      rx_crc_err = crc && (i == n - 1);
    end
    @(posedge clk); #1;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc_err = 1'b0;
    repeat (30) @(posedge clk);
  endtask

  task automatic check_buf(input int bufb, input int n, input int seed, input string req);
    bit ok;
    logic [31:0] act, expv, bad_a, bad_e;
    ok = 1; bad_a = 0; bad_e = 0;
    for (int w = 0; w < (n + 3) / 4; w++) begin
      expv = 0;
      for (int k = 0; k < 4; k++)
        if (w * 4 + k < n) expv[k*8 +: 8] = pat(seed, w * 4 + k);
      act = mem[(bufb >> 2) + w];
      if (ok && act != expv) begin ok = 0; bad_a = act; bad_e = expv; end
    end
    chk(ok, req, bad_a, bad_e);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    rx_valid = 0; rx_data = 0; rx_sof = 0; rx_eof = 0; rx_crc_err = 0;
    for (int i = 0; i < (1 << AW); i++) mem[i] = 32'h0;
    for (int i = 32'h4000 >> 2; i < 32'h4800 >> 2; i++) mem[i] = SENT;
    set_desc(32'h1000, 32'h4000, 32'h1020, 0, 128, 1);
    set_desc(32'h1020, 32'h4200, 32'h1040, 0, 128, 1);
    set_desc(32'h1040, 32'h4400, 32'h0000, 1, 80, 1);
    set_desc(32'h1060, 32'h4600, 32'h1080, 0, 96, 1);
    set_desc(32'h1080, 32'h4700, 32'h0000, 0, 64, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(eoq_flag == 0, "reset eoq_flag", 32'(eoq_flag), 0);
    chk(drop_count == 0, "reset drop_count", 32'(drop_count), 0);
    chk(mem_req == 0, "reset mem_req", 32'(mem_req), 0);

    wr_reg(2'd0, 32'h0000_8001);
    wr_reg(2'd1, 32'h0000_1000);
    wr_reg(2'd2, 32'h8000_0000);
    repeat (10) @(posedge clk);
    @(negedge clk);
    // R1 fetch order
    chk(rd_n >= 4 && rd_log[0] == AW'(32'h400) && rd_log[1] == AW'(32'h402) &&
        rd_log[2] == AW'(32'h403) && rd_log[3] == AW'(32'h405),
        "R1 fetch words", 32'(rd_log[3]), 32'h405);

    push_exp(32'h1000, 70, 32'h0080_0003);
    send_frame(70, 1, 0);
    check_buf(32'h4000, 70, 1, "R2 buffer contents");

    push_exp(32'h1020, 64, 32'h0080_1103);
    send_frame(64, 2, 1);
    check_buf(32'h4200, 64, 2, "R4 next descriptor buffer");

    push_exp(32'h1040, 80, 32'h0050_0903);
    send_frame(100, 3, 0);
    check_buf(32'h4400, 80, 3, "R10 truncated buffer");
    chk(mem[(32'h4400 + 80) >> 2] == SENT, "R10 no write past buffer", mem[(32'h4400 + 80) >> 2], SENT);
    @(negedge clk);
    chk(eoq_flag == 1, "R5 eoq after last", 32'(eoq_flag), 1);

    send_frame(10, 4, 0);
    @(negedge clk);
    chk(drop_count == 1, "R5/R12 frame after end dropped", 32'(drop_count), 1);

    wr_reg(2'd3, 32'h0);
    @(negedge clk);
    chk(eoq_flag == 1, "R6 write 0 keeps flag", 32'(eoq_flag), 1);
    wr_reg(2'd3, 32'h1);
    @(negedge clk);
    chk(eoq_flag == 0, "R6 write 1 clears flag", 32'(eoq_flag), 0);

    wr_reg(2'd1, 32'h0000_1060);
    wr_reg(2'd2, 32'h0000_0000);
    send_frame(12, 5, 0);
    @(negedge clk);
    chk(drop_count == 2, "R7 no start without valid", 32'(drop_count), 2);
    chk(mem[(32'h1060 >> 2) + 5] == 32'h0060_8000, "R7 descriptor untouched",
        mem[(32'h1060 >> 2) + 5], 32'h0060_8000);

    wr_reg(2'd0, 32'h0000_8000);
    wr_reg(2'd2, 32'h8000_0000);
    send_frame(12, 6, 0);
    @(negedge clk);
    chk(drop_count == 3, "R8 run without enable drops", 32'(drop_count), 3);
    chk(mem[(32'h1060 >> 2) + 5] == 32'h0060_8000, "R8 descriptor untouched",
        mem[(32'h1060 >> 2) + 5], 32'h0060_8000);

    wr_reg(2'd0, 32'h0000_8001);
    repeat (10) @(posedge clk);
    push_exp(32'h1060, 20, 32'h0060_0113);
    send_frame(20, 7, 0);
    check_buf(32'h4600, 20, 7, "R11 short frame buffer");
    @(negedge clk);
    chk(eoq_flag == 1, "R9 eoq on unowned descriptor", 32'(eoq_flag), 1);
    chk(mem[(32'h1080 >> 2) + 5] == 32'h0040_0000, "R9 unowned descriptor untouched",
        mem[(32'h1080 >> 2) + 5], 32'h0040_0000);
    send_frame(8, 8, 0);
    @(negedge clk);
    chk(drop_count == 4, "R9/R12 drop after unowned", 32'(drop_count), 4);
    chk(exp_q.size() == 0, "R3 all completions seen", 32'(exp_q.size()), 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule